// File: doc/BRIEF.md
# 4:2:2 Pixel Port Formatter

This block places a 4:2:2 video sample stream onto a 16-bit parallel pixel bus. The bus runs in one of two layouts. In the narrow layout, luma and chroma take turns on the upper byte at the full line-locked rate, and the lower byte is released. In the wide layout, luma on the upper byte and chroma on the lower byte sit side by side and change once per pixel, which is half the full rate.

The block also makes the half-rate companion clock from a toggling flop, keyed to the luma slot. A polarity bit inverts that clock. A small write-only register port sets the layout, picks which clock drives the primary clock pin, and can reverse the order of the two chroma components.

The source holds each pixel's Y, Cb and Cr for two full-rate cycles, starting with the first cycle in which `vid_valid_i` is high. Cb and Cr are co-sited and shared by a pixel pair. The block picks Cb or Cr for each pixel. When the valid input drops, the bus goes low and the phase is rebuilt.

Top module: `vpp_top`

## Requirements
- R1: After reset, the format is narrow (code 0011), the clock-pad select is 000, swap and polarity are 0, `pix_o` is 0, `pix_oe_o` is 16'hFF00 and `clk_half_o` is 0.
- R2: A write to address 0 loads bits [3:0] as the format only when they are 0011 (narrow) or 0010 (wide). Every other code is ignored and the previous format is kept. The format register never holds any other value. Register writes take effect on the next cycle.
- R3: In the narrow format, one cycle after a valid input cycle, `pix_o[15:8]` holds Y if that cycle was the pixel's first (luma) slot, or the selected chroma if it was the second slot. `pix_o[7:0]` is 0 and `pix_oe_o` is 16'hFF00.
- R4: In the wide format, one cycle after a luma slot, `pix_o` is {Y, chroma}. The bus holds that value through the following chroma slot, and `pix_oe_o` is 16'hFFFF.
- R5: Pixels are counted from 0 at the start of each valid run. Even pixels carry Cb and odd pixels carry Cr. When the swap bit (address 2, bit 0) is 1, this order is reversed.
- R6: One cycle after `vid_valid_i` is low, `pix_o` is 0. The next valid cycle is always the luma slot of pixel 0, even if the run was cut off in mid-pixel.
- R7: `clk_half_o` is 1 in the cycle after a luma slot and 0 in the cycle after a chroma slot or an idle cycle. It toggles every cycle while valid is held. The polarity bit (address 2, bit 1) inverts it.
- R8: `clk_pad_o` carries `clk_half_o` when the clock-pad select (address 1, bits [2:0]) is 101. For any other value it carries `clk_i` XOR polarity, so the pin stays at the full rate in the wide format unless 101 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate line-locked clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address (0 format, 1 clock-pad select, 2 control) |
| cfg_wdata_i | input | 8 | Register write data |
| vid_valid_i | input | 1 | Input sample valid |
| vid_y_i | input | 8 | Luma sample, held two cycles per pixel |
| vid_cb_i | input | 8 | Blue-difference chroma of the pixel pair |
| vid_cr_i | input | 8 | Red-difference chroma of the pixel pair |
| pix_o | output | 16 | Pixel bus data |
| pix_oe_o | output | 16 | Per-bit drive enable for the pixel bus (0 = high impedance) |
| clk_half_o | output | 1 | Half-rate companion clock, aligned to luma |
| clk_pad_o | output | 1 | Primary clock pin output |

## Verification
The assertions check four things on every cycle:
- the format register only ever holds one of the two legal codes;
- the bus is zero after an idle cycle;
- the wide bus holds its value through a chroma slot;
- the half-rate clock toggles while valid is held, and every valid run starts on the luma slot of an even pixel.

Some behaviour can only be shown by the bench's scenarios, where a reference model is compared on every clock:
- the chroma selection with and without swap;
- ignoring reserved format codes;
- a run cut off in mid-pixel;
- the effect of polarity on both clock outputs;
- the clock-pad select codes other than 000 and 101.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
  typedef enum logic [3:0] {
    FMT_WIDE   = 4'b0010,
    FMT_NARROW = 4'b0011
  } fmt_e;

  localparam logic [2:0] PAD_HALF = 3'b101;
  localparam logic [1:0] ADDR_FMT = 2'd0;
  localparam logic [1:0] ADDR_PAD = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/vpp_regs.sv
module vpp_regs
  import vpp_pkg::*;
#(
  parameter int AW = 2,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] wdata_i,
  output fmt_e          fmt_o,
  output logic          pad_half_o,
  output logic          swap_o,
  output logic          pol_o
);
  fmt_e       fmt_q;
  logic [2:0] pad_q;
  logic       swap_q, pol_q;
  logic       fmt_ok;

  assign fmt_ok = (wdata_i[3:0] == FMT_WIDE) || (wdata_i[3:0] == FMT_NARROW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_NARROW;
      pad_q  <= 3'b000;
      swap_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == AW'(ADDR_FMT) && fmt_ok) fmt_q <= fmt_e'(wdata_i[3:0]);
      if (addr_i == AW'(ADDR_PAD)) pad_q <= wdata_i[2:0];
      if (addr_i == AW'(ADDR_CTL)) begin
        swap_q <= wdata_i[0];
        pol_q  <= wdata_i[1];
      end
    end
  end

  assign fmt_o      = fmt_q;
  assign pad_half_o = (pad_q == PAD_HALF);
  assign swap_o     = swap_q;
  assign pol_o      = pol_q;
endmodule

// File: rtl/vpp_phase.sv
module vpp_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic slot_o,  // 0 = luma slot, 1 = chroma slot
  output logic odd_o    // pixel parity within the valid run
);
  logic slot_q, odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (!valid_i) begin
      slot_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      slot_q <= ~slot_q;
      if (slot_q) odd_q <= ~odd_q;
    end
  end

  assign slot_o = slot_q;
  assign odd_o  = odd_q;
endmodule

// File: rtl/vpp_fmt.sv
module vpp_fmt
  import vpp_pkg::*;
#(
  parameter int DW = 8,
  parameter int LANES = 2,
  localparam int BW = DW * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fmt_e          fmt_i,
  input  logic          swap_i,
  input  logic          pol_i,
  input  logic          valid_i,
  input  logic          slot_i,
  input  logic          odd_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  output logic [BW-1:0] pix_o,
  output logic [BW-1:0] oe_o,
  output logic          half_o
);
  logic [BW-1:0] bus_q;
  logic          half_q;
  logic [DW-1:0] chroma;

  assign chroma = (odd_i ^ swap_i) ? cr_i : cb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= '0;
      half_q <= 1'b0;
    end else if (!valid_i) begin
      bus_q  <= '0;
      half_q <= pol_i;
    end else begin
      half_q <= ~slot_i ^ pol_i;
      if (fmt_i == FMT_NARROW) bus_q <= {(slot_i ? chroma : y_i), {DW{1'b0}}};
      else if (!slot_i)        bus_q <= {y_i, chroma};
    end
  end

  // upper lane always driven; lower lanes only in the wide format
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == LANES - 1) begin : g_top
      assign oe_o[g*DW +: DW] = '1;
    end else begin : g_low
      assign oe_o[g*DW +: DW] = {DW{fmt_i == FMT_WIDE}};
    end
  end

  assign pix_o  = bus_q;
  assign half_o = half_q;
endmodule

// File: rtl/vpp_top.sv
module vpp_top
  import vpp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int RW = 8,
  localparam int BW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [RW-1:0] cfg_wdata_i,
  input  logic          vid_valid_i,
  input  logic [DW-1:0] vid_y_i,
  input  logic [DW-1:0] vid_cb_i,
  input  logic [DW-1:0] vid_cr_i,
  output logic [BW-1:0] pix_o,
  output logic [BW-1:0] pix_oe_o,
  output logic          clk_half_o,
  output logic          clk_pad_o
);
  fmt_e fmt;
  logic pad_half, swap, pol, slot, odd, half;

  vpp_regs #(.AW(AW), .RW(RW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .fmt_o(fmt), .pad_half_o(pad_half), .swap_o(swap), .pol_o(pol)
  );

  vpp_phase u_phase (
    .clk_i, .rst_ni, .valid_i(vid_valid_i), .slot_o(slot), .odd_o(odd)
  );

  vpp_fmt #(.DW(DW), .LANES(2)) u_fmt (
    .clk_i, .rst_ni,
    .fmt_i(fmt), .swap_i(swap), .pol_i(pol),
    .valid_i(vid_valid_i), .slot_i(slot), .odd_i(odd),
    .y_i(vid_y_i), .cb_i(vid_cb_i), .cr_i(vid_cr_i),
    .pix_o(pix_o), .oe_o(pix_oe_o), .half_o(half)
  );

  assign clk_half_o = half;
  assign clk_pad_o  = pad_half ? half : (clk_i ^ pol);
endmodule

// File: rtl/vpp_chk.sv
module vpp_chk
  import vpp_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2*DW-1:0] pix_i,
  input logic          half_i,
  input fmt_e          fmt_i,
  input logic          slot_i,
  input logic          odd_i,
  input logic          pol_i
);
  a_r2_fmt_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_WIDE) || (fmt_i == FMT_NARROW));

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (pix_i == '0));

  a_r4_wide_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_WIDE && valid_i && slot_i) |=> $stable(pix_i));

  a_r7_half_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i) && pol_i == $past(pol_i)) |=> (half_i != $past(half_i)));

  a_r5_run_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !$past(valid_i)) |-> (!slot_i && !odd_i));
endmodule

bind vpp_top vpp_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(vid_valid_i), .pix_i(pix_o),
  .half_i(clk_half_o), .fmt_i(fmt), .slot_i(slot), .odd_i(odd), .pol_i(pol)
);

// File: tb/tb_vpp_top.sv
module tb_vpp_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        valid = 1'b0;
  logic [7:0]  y = '0, cb = '0, cr = '0;
  logic [15:0] pix, oe;
  logic        half, pad;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench-side view of the configuration
  bit tb_wide = 1'b0;
  bit tb_swap = 1'b0;
  bit tb_pol  = 1'b0;

  always #2.5 clk = ~clk;

  vpp_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .vid_valid_i(valid), .vid_y_i(y), .vid_cb_i(cb),
    .vid_cr_i(cr), .pix_o(pix), .pix_oe_o(oe), .clk_half_o(half),
    .clk_pad_o(pad)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [3:0]  m_fmt;
  logic [2:0]  m_pad;
  bit          m_swap, m_pol, m_slot, m_odd, m_half, m_idle;
  logic [15:0] m_bus;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_fmt <= 4'b0011; m_pad <= 3'b000; m_swap <= 0; m_pol <= 0;
      m_slot <= 0; m_odd <= 0; m_half <= 0; m_bus <= '0; m_idle <= 1;
    end else begin
      logic [7:0] c;
      c = (m_odd ^ m_swap) ? cr : cb;
      if (we) begin
        if (addr == 2'd0 && (wdata[3:0] == 4'b0010 || wdata[3:0] == 4'b0011))
          m_fmt <= wdata[3:0];
        if (addr == 2'd1) m_pad <= wdata[2:0];
        if (addr == 2'd2) begin m_swap <= wdata[0]; m_pol <= wdata[1]; end
      end
      if (valid) begin
        m_idle <= 0;
        m_half <= (!m_slot) ^ m_pol;
        if (m_fmt == 4'b0011) m_bus <= {(m_slot ? c : y), 8'h00};
        else if (!m_slot) m_bus <= {y, c};
        if (m_slot) m_odd <= !m_odd;
        m_slot <= !m_slot;
      end else begin
        m_idle <= 1; m_bus <= '0; m_half <= m_pol; m_slot <= 0; m_odd <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [15:0] e_oe;
      logic        e_pad;
      e_oe  = (m_fmt == 4'b0011) ? 16'hFF00 : 16'hFFFF;
      e_pad = (m_pad == 3'b101) ? m_half : m_pol;
      chk(pix === m_bus, m_idle ? "R6 bus" : (m_fmt == 4'b0011 ? "R3 bus" : "R4 bus"),
          pix, m_bus);
      chk(oe === e_oe, (m_fmt == 4'b0011) ? "R3 oe" : "R4 oe", oe, e_oe);
      chk(half === m_half, "R7 half clock", {15'd0, half}, {15'd0, m_half});
      chk(pad === e_pad, "R8 pad clock", {15'd0, pad}, {15'd0, e_pad});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // burst of n pixels from an idle start; directed R5 chroma order check
  task automatic burst(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e_c;
      valid = 1'b1; y = 8'h10 + 8'(k); cb = 8'h80 + 8'(k); cr = 8'hC0 + 8'(k);
      e_c = ((k % 2 == 1) ^ tb_swap) ? cr : cb;
      @(negedge clk);
      if (tb_wide) chk(pix[7:0] === e_c, "R5 wide chroma", {8'h00, pix[7:0]}, {8'h00, e_c});
      @(negedge clk);
      if (!tb_wide) chk(pix[15:8] === e_c, "R5 narrow chroma", {8'h00, pix[15:8]}, {8'h00, e_c});
    end
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is still held
    chk(pix === 16'h0, "R1 bus", pix, 16'h0);
    chk(oe === 16'hFF00, "R1 oe", oe, 16'hFF00);
    chk(half === 1'b0, "R1 half clock", {15'd0, half}, 16'h0);
    chk(pad === 1'b0, "R1 pad clock", {15'd0, pad}, 16'h0);
    rst_ni = 1'b1;
    idle(2);

    burst(6); idle(3);
    wr(2'd2, 8'h01); tb_swap = 1; burst(4); idle(2);
    wr(2'd2, 8'h00); tb_swap = 0;

    wr(2'd0, 8'h07);
    chk(oe === 16'hFF00, "R2 reserved ignored", oe, 16'hFF00);
    wr(2'd0, 8'h00);
    chk(oe === 16'hFF00, "R2 other code ignored", oe, 16'hFF00);
    wr(2'd0, 8'h02); tb_wide = 1;
    chk(oe === 16'hFFFF, "R2 wide accepted", oe, 16'hFFFF);
    burst(5); idle(1);
    // R6: run cut off in mid-pixel, then restart
    valid = 1'b1; y = 8'h55; cb = 8'h66; cr = 8'h77;
    @(negedge clk);
    idle(2);
    burst(3); idle(2);
    wr(2'd2, 8'h03); tb_swap = 1; tb_pol = 1; burst(3); idle(2);

    wr(2'd1, 8'h05); burst(4);
    chk(pad === half, "R8 pad follows half clock", {15'd0, pad}, {15'd0, half});
    idle(2);
    wr(2'd1, 8'h06);
    chk(pad === 1'b1, "R8 code 110 acts as full rate", {15'd0, pad}, 16'h1);
    wr(2'd0, 8'h0B);
    chk(oe === 16'hFFFF, "R2 reserved 1011 ignored", oe, 16'hFFFF);
    wr(2'd0, 8'h03); tb_wide = 0;
    chk(oe === 16'hFF00, "R2 narrow accepted", oe, 16'hFF00);
    burst(3); idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule